// File: doc/BRIEF.md
# Memory-Mapped 32-Source Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and folds them into one interrupt output for a CPU priority level. Software reaches it through a simple synchronous register port. Each instance answers within its own 4 KiB window, addressed by byte offset. Each source has an enable bit. A source is pending when its request line is high and its enable bit is set. The interrupt output is raised whenever any source is pending.

The enable mask cannot be written directly. A write-one-to-set register turns sources on. A write-one-to-clear register turns them off. A third register switches every source off with a single write, whatever the data. Software reads the pending vector to find which sources need service, and can also read a count of how many sources are pending. Requests are not latched: a line that drops takes its pending bit with it.

Registers are 32 bits wide. Bit n of every mask and of the pending vector stands for source n, with bit 0 as the lowest source. The bus carries each register as one 32-bit word with the most significant byte first. A read returns its data on `rd_data` in the cycle after `rd_en` is sampled. In every cycle without a read, `rd_data` is zero.

Top module: `irqc_top`

## Requirements
- R1: After reset all enable bits are 0, `irq_out` is low and `rd_data` is 0.
- R2: A read of byte offset 0x04 returns the pending vector: bit n is 1 exactly when request line n is high and source n is enabled. Read data appears on `rd_data` in the cycle after the read is sampled. The value reflects requests and enables as they stood one edge before the read.
- R3: A write to offset 0x10 sets every enable bit whose data bit is 1 and leaves the other enable bits unchanged. The new mask takes part in the pending vector from the next clock edge on.
- R4: A write to offset 0x0C clears every enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R5: Any write to offset 0x08 clears all enable bits, whatever the data value.
- R6: `irq_out` is high exactly when the registered pending vector is nonzero.
- R7: A read of offset 0x00 returns the number of set bits in the pending vector, from 0 to 32, in the low bits of the word.
- R8: Reads of offsets 0x08, 0x0C, 0x10, of any other offset, and of offsets whose two low bits are not zero return 0. `rd_data` is 0 in every cycle that follows a cycle without a read.
- R9: Writes to offsets 0x00, 0x04, to unmapped offsets and to offsets whose two low bits are not zero leave the enable mask unchanged.
- R10: Requests are level-sensitive: when a request line drops, its pending bit and, if it was the only one, `irq_out` fall one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 32 | Level interrupt request lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset within the 4 KiB window |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Read data word, valid the cycle after `rd_en` |
| irq_out | output | 1 | Combined interrupt output toward the CPU |

## Verification
Two functions can act in the same clock cycle: a change on the request lines and a write to the enable or disable register. The bench provokes this by raising or dropping request lines in the very cycle that a set, clear or clear-all write is sampled. A behavioural model then judges the outcome on every clock. The model expects the first pending value to combine the new requests with the old mask, and the next value to use the new mask. Reads issued in the cycle of a mask write are judged the same way: they must return the pending value from before that edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register selection produced by the address decoder.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_PEND,
        SEL_KILL,
        SEL_OFF,
        SEL_ON
    } reg_sel_e;

    // Byte offsets inside the window; software depends on these values.
    localparam int unsigned OFS_COUNT = 32'h00;
    localparam int unsigned OFS_PEND  = 32'h04;
    localparam int unsigned OFS_KILL  = 32'h08;
    localparam int unsigned OFS_OFF   = 32'h0C;
    localparam int unsigned OFS_ON    = 32'h10;

endpackage

// File: rtl/irqc_addr_decode.sv
module irqc_addr_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Full-width compare: unaligned offsets never hit a register.
    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFS_COUNT))
            sel = SEL_COUNT;
        else if (addr == ADDR_W'(OFS_PEND))
            sel = SEL_PEND;
        else if (addr == ADDR_W'(OFS_KILL))
            sel = SEL_KILL;
        else if (addr == ADDR_W'(OFS_OFF))
            sel = SEL_OFF;
        else if (addr == ADDR_W'(OFS_ON))
            sel = SEL_ON;
    end

endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [N_SRC-1:0] mask,
    output logic [N_SRC-1:0] en_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_ON:   en_q <= en_q | mask;
                SEL_OFF:  en_q <= en_q & ~mask;
                SEL_KILL: en_q <= '0;
                default:  en_q <= en_q;
            endcase
        end
    end

endmodule

// File: rtl/irqc_pending_stage.sv
module irqc_pending_stage #(
    parameter int N_SRC = 32,
    localparam int CNT_W = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] pend_q,
    output logic [CNT_W-1:0] pend_cnt,
    output logic             irq_any
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= req & en_q;
    end

    always_comb begin
        pend_cnt = '0;
        for (int i = 0; i < N_SRC; i++)
            pend_cnt = pend_cnt + CNT_W'(pend_q[i]);
    end

    assign irq_any = |pend_q;

endmodule

// File: rtl/irqc_read_port.sv
module irqc_read_port
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(N_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [N_SRC-1:0]  pend_q,
    input  logic [CNT_W-1:0]  pend_cnt,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (sel)
                SEL_COUNT: rd_data <= DATA_W'(pend_cnt);
                SEL_PEND:  rd_data <= DATA_W'(pend_q);
                default:   rd_data <= '0;
            endcase
        end else begin
            rd_data <= '0;
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_SRC        = 32,
    parameter int DATA_W       = 32,
    parameter int WINDOW_BYTES = 4096,
    localparam int ADDR_W      = $clog2(WINDOW_BYTES),
    localparam int CNT_W       = $clog2(N_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_out
);

    reg_sel_e         sel;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] pend_q;
    logic [CNT_W-1:0] pend_cnt;

    irqc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    irqc_enable_bank #(.N_SRC(N_SRC)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .mask  (wr_data[N_SRC-1:0]),
        .en_q  (en_q)
    );

    irqc_pending_stage #(.N_SRC(N_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .en_q     (en_q),
        .pend_q   (pend_q),
        .pend_cnt (pend_cnt),
        .irq_any  (irq_out)
    );

    irqc_read_port #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (sel),
        .pend_q   (pend_q),
        .pend_cnt (pend_cnt),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  irq_req,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_out
);

    // R6: an asserted output needs some request one edge earlier.
    a_r6_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ($past(irq_req) != '0));

    // R10: with every request low, the output is low one edge later.
    a_r10_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req == '0) |=> !irq_out);

    // R5: clear-all write silences the output two edges later.
    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_KILL)) |=> ##1 !irq_out);

    // R4: disabling every source silences the output two edges later.
    a_r4_disable_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_OFF) && wr_data[N_SRC-1:0] == '1)
        |=> ##1 !irq_out);

    // R8: reading the set-enable offset returns zero.
    a_r8_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_ON)) |=> (rd_data == '0));

    // R8: no read, no data.
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    // R7: the count never exceeds the number of sources.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_COUNT)) |=> (rd_data <= DATA_W'(N_SRC)));

endmodule

bind irqc_top irqc_checker #(
    .N_SRC  (N_SRC),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string cur_tag  = "R1";

    always #10 clk = ~clk;   // 50 MHz

    irqc_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_out (irq_out)
    );

    // Behavioural reference model, updated on every rising edge.
    logic [31:0] m_en = '0;
    logic [31:0] m_pend = '0;
    logic [31:0] m_rd = '0;

    function automatic int ones(input logic [31:0] v);
        int c = 0;
        foreach (v[i]) if (v[i]) c++;
        return c;
    endfunction

    always @(posedge clk) begin
        logic [31:0] nrd;
        logic [31:0] nen;
        nrd = '0;
        nen = m_en;
        if (!rst_n) begin
            m_en = '0; m_pend = '0; m_rd = '0;
        end else begin
            if (rd_en) begin
                if (addr == 12'h000) nrd = 32'(ones(m_pend));
                else if (addr == 12'h004) nrd = m_pend;
            end
            if (wr_en) begin
                if (addr == 12'h010) nen = m_en | wr_data;
                else if (addr == 12'h00C) nen = m_en & ~wr_data;
                else if (addr == 12'h008) nen = '0;
            end
            m_rd   = nrd;
            m_pend = irq_req & m_en;
            m_en   = nen;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_tag, " model irq_out"}, 32'(irq_out), 32'(m_pend != '0));
            check({cur_tag, " model rd_data"}, rd_data, m_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 irq_out in reset", 32'(irq_out), 32'h0);
        check("R1 rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        irq_req = 32'hFFFF_FFFF;
        idle(2);
        check("R1 nothing enabled", 32'(irq_out), 32'h0);
        rd(12'h004, 32'h0, "R1 pending after reset");

        // R3 set enables
        cur_tag = "R3";
        wr(12'h010, 32'h0000_00A5);
        idle(1);
        rd(12'h004, 32'h0000_00A5, "R3 pending after enable");
        cur_tag = "R7";
        rd(12'h000, 32'd4, "R7 count of four");
        cur_tag = "R3";
        wr(12'h010, 32'h8000_0100);
        idle(1);
        rd(12'h004, 32'h8000_01A5, "R3 others unchanged");

        // R4 clear selected enables
        cur_tag = "R4";
        wr(12'h00C, 32'h0000_0005);
        idle(1);
        rd(12'h004, 32'h8000_01A0, "R4 selected bits off");

        // R2 pending follows request pattern
        cur_tag = "R2";
        irq_req = 32'h0000_0021;
        idle(1);
        rd(12'h004, 32'h0000_0020, "R2 masked pattern");
        irq_req = 32'h8000_0000;
        idle(1);
        rd(12'h004, 32'h8000_0000, "R2 top source");
        check("R6 irq high with pending", 32'(irq_out), 32'h1);

        // R10 level drop
        cur_tag = "R10";
        irq_req = '0;
        @(negedge clk);
        check("R10 irq falls one edge after drop", 32'(irq_out), 32'h0);
        check("R6 irq low with nothing pending", 32'(irq_out), 32'h0);

        // R9 ignored writes
        cur_tag = "R9";
        irq_req = 32'hFFFF_FFFF;
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'hFFC, 32'hFFFF_FFFF);
        wr(12'h011, 32'hFFFF_FFFF);
        wr(12'h00D, 32'hFFFF_FFFF);
        wr(12'h009, 32'h0);
        idle(1);
        rd(12'h004, 32'h8000_01A0, "R9 mask unchanged");

        // R8 write-only and unmapped reads
        cur_tag = "R8";
        rd(12'h008, 32'h0, "R8 read clear-all offset");
        rd(12'h00C, 32'h0, "R8 read disable offset");
        rd(12'h010, 32'h0, "R8 read enable offset");
        rd(12'h100, 32'h0, "R8 read unmapped");
        rd(12'h005, 32'h0, "R8 read unaligned");
        @(negedge clk);
        check("R8 idle rd_data", rd_data, 32'h0);

        // Collision: request change in the cycle of a mask write
        cur_tag = "R3";
        irq_req = 32'h0000_0002;
        wr(12'h010, 32'h0000_0002);
        check("R3 old mask on first edge", 32'(irq_out), 32'h0);
        @(negedge clk);
        check("R3 new mask on next edge", 32'(irq_out), 32'h1);
        cur_tag = "R4";
        irq_req = 32'h0000_0003;
        wr(12'h00C, 32'h0000_0002);
        check("R4 old mask still pending", 32'(irq_out), 32'h1);
        @(negedge clk);
        check("R4 disable takes effect", 32'(irq_out), 32'h0);

        // R5 clear all with zero data
        cur_tag = "R5";
        irq_req = 32'hFFFF_FFFF;
        idle(1);
        check("R5 pending before clear", 32'(irq_out), 32'h1);
        wr(12'h008, 32'h0);
        @(negedge clk);
        check("R5 clear-all", 32'(irq_out), 32'h0);
        rd(12'h004, 32'h0, "R5 pending zero");

        // R7 full count
        cur_tag = "R7";
        wr(12'h010, 32'hFFFF_FFFF);
        idle(1);
        rd(12'h000, 32'd32, "R7 count of 32");
        rd(12'h004, 32'hFFFF_FFFF, "R2 all pending");
        irq_req = 32'h0000_0001;
        idle(1);
        rd(12'h000, 32'd1, "R7 count of one");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule